// File: doc/BRIEF.md
# Unanimous-Window Sticky Glitch Filter

This block cleans a slowly slewing, noisy single-bit input so that the logic behind it sees only one clean transition per real change. The raw pin is first passed through a flip-flop synchronizer. The synchronized level is then shifted into a short window register on every sample tick. A sticky output flop goes to 1 only when the whole window holds ones. It goes to 0 only when the whole window holds zeros. Any mixed window leaves the output where it was. This gives a digital hysteresis band as wide as the window. The chatter a slow edge produces while it crosses the undefined threshold region cannot reach the output.

Sample ticks come from an internal divider. With a ratio above one, a short window can still span a transition that lasts many clock periods. The window must last longer, in sample periods, than the slowest full rise or fall of the input. The block also reports one-cycle pulses when the clean level rises or falls.

Top module: `glitch_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the clean output equals the IDLE_LEVEL parameter and both edge pulses are 0. The synchronizer and window are preloaded with IDLE_LEVEL.
- R2: The input passes through SYNC_STAGES flip-flops before it reaches the window. With DIV_RATIO=1, a level change on the input that is held steady appears on the clean output after exactly SYNC_STAGES+WIN_LEN+1 rising edges, which is 7 edges with the default parameters.
- R3: The clean output becomes 1 only after WIN_LEN consecutive samples of 1 have filled the window.
- R4: The clean output becomes 0 only after WIN_LEN consecutive samples of 0 have filled the window.
- R5: A window holding both ones and zeros leaves the clean output unchanged. An input excursion shorter than WIN_LEN sample periods, and a fast alternating input, never change the output.
- R6: A sample is taken once every DIV_RATIO clock cycles, and the window shifts only on those cycles. With DIV_RATIO=3 and WIN_LEN=4, an 8-cycle excursion is rejected and a 30-cycle level is accepted.
- R7: The rise pulse is 1 for exactly one cycle, in the first cycle in which the clean output reads 1.
- R8: The fall pulse is 1 for exactly one cycle, in the first cycle in which the clean output reads 0. The two pulses are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| rawIn | input | 1 | Asynchronous, slowly slewing input level |
| cleanOut | output | 1 | Filtered sticky level |
| risePulse | output | 1 | One-cycle pulse on a clean 0-to-1 change |
| fallPulse | output | 1 | One-cycle pulse on a clean 1-to-0 change |

## Verification
The bench goes after the exact latency edge: the output must still read the old level after six edges and the new one after the seventh. A design with a missing synchronizer stage or a registered comparison would miss this by one cycle. Excursions one sample short of the window, and a fast alternating input, show whether the output follows a majority vote or a partial window instead of holding. Pulse checks in the cycles just before, at and just after each change catch pulses that are stretched, missing or tied to the wrong edge. A second instance uses a divided tick and the opposite idle level. An 8-cycle excursion must be rejected there, so a divider that samples every clock, or that shifts on every cycle, lets that excursion through. A wrong reset fill shows up as a bad first level or a spurious pulse.

// File: rtl/glitch_filter_pkg.sv
package glitch_filter_pkg;

  // Strobes from the sample controller to the window datapath.
  typedef struct packed {
    logic sampleEn;
  } gf_strobe_t;

endpackage

// File: rtl/gf_sample_ctrl.sv
module gf_sample_ctrl
  import glitch_filter_pkg::*;
#(
  parameter int DIV_RATIO = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  output gf_strobe_t strobes
);

  localparam int CNT_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;

  generate
    if (DIV_RATIO <= 1) begin : g_every_clock
      always_comb begin
        strobes = '0;
        strobes.sampleEn = 1'b1;
      end
    end else begin : g_divided
      logic [CNT_W-1:0] divCnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          divCnt <= '0;
        end else if (divCnt == CNT_W'(DIV_RATIO - 1)) begin
          divCnt <= '0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end

      always_comb begin
        strobes = '0;
        strobes.sampleEn = (divCnt == CNT_W'(DIV_RATIO - 1));
      end

      // R6
      sample_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobes.sampleEn |=> !strobes.sampleEn);

      // R6
      div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        divCnt <= CNT_W'(DIV_RATIO - 1));
    end
  endgenerate

endmodule

// File: rtl/gf_window_path.sv
module gf_window_path
  import glitch_filter_pkg::*;
#(
  parameter int WIN_LEN     = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit IDLE_LEVEL  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  gf_strobe_t strobes,
  input  logic       rawIn,
  output logic       cleanOut,
  output logic       risePulse,
  output logic       fallPulse
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [WIN_LEN-1:0]     window;
  logic                   cleanQ;
  logic                   cleanPrev;
  logic                   allOnes;
  logic                   allZeros;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncChain <= {SYNC_STAGES{IDLE_LEVEL}};
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], rawIn};
    end
  end

  // Newest sample enters bit 0 on each tick.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      window <= {WIN_LEN{IDLE_LEVEL}};
    end else if (strobes.sampleEn) begin
      window <= {window[WIN_LEN-2:0], syncChain[SYNC_STAGES-1]};
    end
  end

  assign allOnes  = &window;
  assign allZeros = ~|window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cleanQ    <= IDLE_LEVEL;
      cleanPrev <= IDLE_LEVEL;
    end else begin
      cleanPrev <= cleanQ;
      if (allOnes) begin
        cleanQ <= 1'b1;
      end else if (allZeros) begin
        cleanQ <= 1'b0;
      end
    end
  end

  assign cleanOut  = cleanQ;
  assign risePulse = cleanQ & ~cleanPrev;
  assign fallPulse = ~cleanQ & cleanPrev;

  // R3
  rise_needs_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cleanQ) |-> ($past(window) == {WIN_LEN{1'b1}}));

  // R4
  fall_needs_zeros_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cleanQ) |-> ($past(window) == {WIN_LEN{1'b0}}));

  // R5
  mixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!allOnes && !allZeros) |=> $stable(cleanQ));

  // R6
  shift_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.sampleEn |=> $stable(window));

  // R7
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    risePulse |=> !risePulse);

  // R8
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fallPulse |=> !fallPulse);

  // R8
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({risePulse, fallPulse}) <= 1);

endmodule

// File: rtl/glitch_filter.sv
module glitch_filter
  import glitch_filter_pkg::*;
#(
  parameter int WIN_LEN     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_RATIO   = 1,
  parameter bit IDLE_LEVEL  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rawIn,
  output logic cleanOut,
  output logic risePulse,
  output logic fallPulse
);

  gf_strobe_t strobes;

  gf_sample_ctrl #(
    .DIV_RATIO(DIV_RATIO)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes)
  );

  gf_window_path #(
    .WIN_LEN     (WIN_LEN),
    .SYNC_STAGES (SYNC_STAGES),
    .IDLE_LEVEL  (IDLE_LEVEL)
  ) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .rawIn     (rawIn),
    .cleanOut  (cleanOut),
    .risePulse (risePulse),
    .fallPulse (fallPulse)
  );

endmodule

// File: tb/glitch_filter_tb.sv
`timescale 1ns/1ps
module glitch_filter_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rawA = 1'b0;
  logic rawB = 1'b1;
  logic cleanA, riseA, fallA;
  logic cleanB, riseB, fallB;
  int   errors = 0;
  int   checks = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  glitch_filter u_dut (
    .clk(clk), .rst_n(rst_n), .rawIn(rawA),
    .cleanOut(cleanA), .risePulse(riseA), .fallPulse(fallA)
  );

  glitch_filter #(.DIV_RATIO(3), .IDLE_LEVEL(1'b1)) u_dutDiv (
    .clk(clk), .rst_n(rst_n), .rawIn(rawB),
    .cleanOut(cleanB), .risePulse(riseB), .fallPulse(fallB)
  );

  typedef struct packed {
    logic lvl;
    int   hold;
    logic exp;
    int   req;
  } vec_t;

  // Level, edges to hold it, expected clean level afterwards, requirement.
  localparam vec_t VECS [14] = '{
    '{1'b1,  3, 1'b0, 5},   // R5 short high excursion ignored
    '{1'b0, 10, 1'b0, 4},   // R4 settle low
    '{1'b1,  6, 1'b0, 2},   // R2 one edge before the rise
    '{1'b1,  1, 1'b1, 3},   // R3 seventh edge: window all ones
    '{1'b0,  3, 1'b1, 5},   // R5 short low excursion ignored
    '{1'b1,  8, 1'b1, 3},   // R3 stays high
    '{1'b0,  6, 1'b1, 2},   // R2 one edge before the fall
    '{1'b0,  1, 1'b0, 4},   // R4 seventh edge: window all zeros
    '{1'b1,  1, 1'b0, 5},   // R5 alternating input
    '{1'b0,  1, 1'b0, 5},
    '{1'b1,  1, 1'b0, 5},
    '{1'b0,  1, 1'b0, 5},
    '{1'b1,  3, 1'b0, 5},   // R5 mixed window holds low
    '{1'b0, 12, 1'b0, 4}    // R4 settle low again
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int fallCount;
    int stayHigh;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 cleanA", cleanA, 1'b0);
    check("R1 riseA", riseA, 1'b0);
    check("R1 fallA", fallA, 1'b0);
    check("R1 cleanB", cleanB, 1'b1);
    rst_n = 1'b1;
    step(1);
    check("R1 fallB after reset", fallB, 1'b0);

    foreach (VECS[i]) begin
      rawA = VECS[i].lvl;
      step(VECS[i].hold);
      check($sformatf("R%0d row %0d", VECS[i].req, i), cleanA, VECS[i].exp);
    end

    // R7 rise pulse timing
    rawA = 1'b1;
    step(6);
    check("R7 no early rise", riseA, 1'b0);
    step(1);
    check("R7 rise pulse", riseA, 1'b1);
    check("R7 clean with pulse", cleanA, 1'b1);
    step(1);
    check("R7 rise one cycle", riseA, 1'b0);
    // R8 fall pulse timing
    rawA = 1'b0;
    step(6);
    check("R8 no early fall", fallA, 1'b0);
    step(1);
    check("R8 fall pulse", fallA, 1'b1);
    check("R8 no rise during fall", riseA, 1'b0);
    step(1);
    check("R8 fall one cycle", fallA, 1'b0);

    // R6 divided sampling: 8-cycle low excursion rejected
    stayHigh = 1;
    rawB = 1'b0;
    for (int k = 0; k < 8; k++) begin
      step(1);
      if (cleanB !== 1'b1) stayHigh = 0;
    end
    rawB = 1'b1;
    for (int k = 0; k < 20; k++) begin
      step(1);
      if (cleanB !== 1'b1) stayHigh = 0;
    end
    check("R6 short excursion rejected", stayHigh[0], 1'b1);
    // R6 long low accepted, with one fall pulse (R8)
    fallCount = 0;
    rawB = 1'b0;
    for (int k = 0; k < 30; k++) begin
      step(1);
      if (fallB === 1'b1) fallCount++;
    end
    check("R6 long level accepted", cleanB, 1'b0);
    check("R8 single fall pulse divided", fallCount == 1, 1'b1);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule